// File: doc/BRIEF.md
# Memory Operand Offset Generator

This block computes the 32-bit offset of a memory operand from fields an instruction decoder has already split out: the two-bit mode, the three-bit register/memory selector, the three fields of the scaled-index byte, a displacement word, and an optional segment override. It reads a flattened copy of the eight general registers, picks the base and index values the encoding calls for, scales the index, sign-extends a short displacement when the mode asks for one, and adds the three terms modulo 2^32. It also picks the segment register the access uses.

The encoding has irregular corners, and the block follows them: direct addressing with no base, a scaled-index form with no base, an index code that adds nothing, and the frame-pointer base that is only reachable with a displacement present. The default segment follows the chosen base register. A register-only encoding (mode 11) produces no address and raises a flag instead. Each accepted request gives a result one clock later, marked by a valid pulse.

Top module: `mem_offset_agu`

## Requirements
- R1: A request with `in_valid` high at a rising edge gives `out_valid` high for exactly the cycle after that edge; with `in_valid` low, `out_valid` is low one cycle later.
- R2: Register codes 0 to 7 select EAX, ECX, EDX, EBX, ESP, EBP, ESI, EDI, packed in `gpr_bus` at bits [32*k+31:32*k] for code k. When `rm_code` is not 100 (and not the direct form), that register is the base and no index is used.
- R3: When `rm_code` is 100 the scaled-index fields are used; scale code 00, 01, 10, 11 multiplies the index register by 1, 2, 4, 8 before the add.
- R4: Mode 00 adds no displacement (except the forms in R5 and R6), mode 01 adds `disp_in[7:0]` sign-extended to 32 bits, mode 10 adds all of `disp_in`.
- R5: Mode 00 with `rm_code` 101 is direct addressing: the offset equals `disp_in` and the default segment is DS.
- R6: Mode 00 with `rm_code` 100 and index-byte base 101 has no base register: the offset is `disp_in` plus the scaled index, default segment DS.
- R7: In modes 01 and 10 a base code of 101 (in either `rm_code` or the index-byte base) selects EBP as base.
- R8: An index code of 100 adds zero, whatever the scale.
- R9: The default segment is SS (code 2) when the base is ESP or EBP, otherwise DS (code 3). Segment codes: ES 0, CS 1, SS 2, DS 3, FS 4, GS 5.
- R10: With `seg_ovr_en` high on a memory form, `out_seg` equals `seg_ovr_code` in place of the default.
- R11: Mode 11 gives `out_no_mem` high, `out_offset` zero and `out_seg` DS (code 3), ignoring any override.
- R12: The sum wraps modulo 2^32.
- R13: While reset is asserted, `out_valid` and `out_no_mem` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| mod_code | input | 2 | Mode field |
| rm_code | input | 3 | Register/memory selector |
| sib_scale | input | 2 | Scale code |
| sib_index | input | 3 | Index register code |
| sib_base | input | 3 | Base register code from the index byte |
| disp_in | input | 32 | Displacement (low byte used in mode 01) |
| seg_ovr_en | input | 1 | Segment override present |
| seg_ovr_code | input | 3 | Override segment code |
| gpr_bus | input | 256 | Eight 32-bit registers, code k at bits [32k+31:32k] |
| out_valid | output | 1 | Result valid |
| out_offset | output | 32 | Computed offset |
| out_seg | output | 3 | Selected segment code |
| out_no_mem | output | 1 | Register-only form, no address |

## Verification
The bench builds the block with its defaults, a 32-bit data path and an 8-bit short displacement. These put the sign bit of the short displacement at bit 7, so a byte of 0xF8 must subtract 8, and put the wrap point at 2^32, where a base of 0xFFFFFFF0 plus 0x20 must land on 0x10. Register values are chosen distinct so a wrong base or index selection or a wrong scale shows in the offset.

// File: rtl/agu_pkg.sv
package agu_pkg;
  localparam int REG_SEL_W = 3;
  localparam int NUM_GPR   = 8;
  localparam int SEG_W     = 3;

  localparam logic [REG_SEL_W-1:0] CODE_ESP = 3'b100;
  localparam logic [REG_SEL_W-1:0] CODE_EBP = 3'b101;
  localparam logic [REG_SEL_W-1:0] CODE_SIB = 3'b100;
  localparam logic [REG_SEL_W-1:0] CODE_NOIDX = 3'b100;
  localparam logic [REG_SEL_W-1:0] CODE_DIRECT = 3'b101;

  localparam logic [SEG_W-1:0] SEG_SS = 3'd2;
  localparam logic [SEG_W-1:0] SEG_DS = 3'd3;

  typedef enum logic [1:0] {
    DSP_NONE = 2'd0,
    DSP_BYTE = 2'd1,
    DSP_WORD = 2'd2
  } disp_kind_e;

  typedef struct packed {
    logic                 no_mem;
    logic                 base_en;
    logic [REG_SEL_W-1:0] base_sel;
    logic                 idx_en;
    logic [REG_SEL_W-1:0] idx_sel;
    logic [1:0]           scale;
    disp_kind_e           disp;
    logic [SEG_W-1:0]     dflt_seg;
  } agu_decode_t;
endpackage

// File: rtl/agu_decode.sv
module agu_decode
  import agu_pkg::*;
(
  input  logic [1:0]           mod_code,
  input  logic [REG_SEL_W-1:0] rm_code,
  input  logic [1:0]           sib_scale,
  input  logic [REG_SEL_W-1:0] sib_index,
  input  logic [REG_SEL_W-1:0] sib_base,
  output agu_decode_t          dec
);
  always_comb begin
    dec          = '0;
    dec.disp     = DSP_NONE;
    dec.dflt_seg = SEG_DS;
    if (mod_code == 2'b11) begin
      dec.no_mem = 1'b1;
    end else begin
      case (mod_code)
        2'b01:   dec.disp = DSP_BYTE;
        2'b10:   dec.disp = DSP_WORD;
        default: dec.disp = DSP_NONE;
      endcase
      if (rm_code == CODE_SIB) begin
        dec.idx_en  = (sib_index != CODE_NOIDX);
        dec.idx_sel = sib_index;
        dec.scale   = sib_scale;
        if (mod_code == 2'b00 && sib_base == CODE_EBP) begin
          dec.base_en = 1'b0;
          dec.disp    = DSP_WORD;
        end else begin
          dec.base_en  = 1'b1;
          dec.base_sel = sib_base;
        end
      end else if (mod_code == 2'b00 && rm_code == CODE_DIRECT) begin
        dec.base_en = 1'b0;
        dec.disp    = DSP_WORD;
      end else begin
        dec.base_en  = 1'b1;
        dec.base_sel = rm_code;
      end
      if (dec.base_en && (dec.base_sel == CODE_ESP || dec.base_sel == CODE_EBP))
        dec.dflt_seg = SEG_SS;
    end
  end
endmodule

// File: rtl/agu_operand_sel.sv
module agu_operand_sel
  import agu_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int SHORT_DISP_W = 8,
  localparam int GPR_BUS_W   = NUM_GPR * DATA_W,
  localparam int EXT_W       = DATA_W - SHORT_DISP_W
) (
  input  agu_decode_t          dec,
  input  logic [GPR_BUS_W-1:0] gpr_bus,
  input  logic [DATA_W-1:0]    disp_in,
  output logic [DATA_W-1:0]    base_term,
  output logic [DATA_W-1:0]    idx_term,
  output logic [DATA_W-1:0]    disp_term
);
  logic [DATA_W-1:0] regs [NUM_GPR];

  for (genvar g = 0; g < NUM_GPR; g++) begin : g_unpack
    assign regs[g] = gpr_bus[g*DATA_W +: DATA_W];
  end

  always_comb begin
    base_term = dec.base_en ? regs[dec.base_sel] : '0;
    idx_term  = dec.idx_en ? (regs[dec.idx_sel] << dec.scale) : '0;
    case (dec.disp)
      DSP_BYTE: disp_term = {{EXT_W{disp_in[SHORT_DISP_W-1]}}, disp_in[SHORT_DISP_W-1:0]};
      DSP_WORD: disp_term = disp_in;
      default:  disp_term = '0;
    endcase
  end
endmodule

// File: rtl/agu_adder.sv
module agu_adder #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] term_a,
  input  logic [DATA_W-1:0] term_b,
  input  logic [DATA_W-1:0] term_c,
  output logic [DATA_W-1:0] sum
);
  always_comb sum = term_a + term_b + term_c;
endmodule

// File: rtl/agu_rst_sync.sv
module agu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_core_n = chain_q[STAGES-1];
endmodule

// File: rtl/mem_offset_agu.sv
module mem_offset_agu
  import agu_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int SHORT_DISP_W = 8,
  localparam int GPR_BUS_W   = NUM_GPR * DATA_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [1:0]           mod_code,
  input  logic [2:0]           rm_code,
  input  logic [1:0]           sib_scale,
  input  logic [2:0]           sib_index,
  input  logic [2:0]           sib_base,
  input  logic [DATA_W-1:0]    disp_in,
  input  logic                 seg_ovr_en,
  input  logic [2:0]           seg_ovr_code,
  input  logic [GPR_BUS_W-1:0] gpr_bus,
  output logic                 out_valid,
  output logic [DATA_W-1:0]    out_offset,
  output logic [2:0]           out_seg,
  output logic                 out_no_mem
);
  logic              rst_core_n;
  agu_decode_t       dec;
  logic [DATA_W-1:0] base_term, idx_term, disp_term, sum;

  logic              valid_d, valid_q;
  logic              nomem_d, nomem_q;
  logic [DATA_W-1:0] offset_d, offset_q;
  logic [SEG_W-1:0]  seg_d, seg_q;
  logic              data_en;

  agu_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  agu_decode u_decode (
    .mod_code  (mod_code),
    .rm_code   (rm_code),
    .sib_scale (sib_scale),
    .sib_index (sib_index),
    .sib_base  (sib_base),
    .dec       (dec)
  );

  agu_operand_sel #(.DATA_W(DATA_W), .SHORT_DISP_W(SHORT_DISP_W)) u_opsel (
    .dec       (dec),
    .gpr_bus   (gpr_bus),
    .disp_in   (disp_in),
    .base_term (base_term),
    .idx_term  (idx_term),
    .disp_term (disp_term)
  );

  agu_adder #(.DATA_W(DATA_W)) u_adder (
    .term_a (base_term),
    .term_b (idx_term),
    .term_c (disp_term),
    .sum    (sum)
  );

  // next-state
  always_comb begin
    valid_d = in_valid;
    data_en = in_valid;
    nomem_d = dec.no_mem;
    if (dec.no_mem) begin
      offset_d = '0;
      seg_d    = SEG_DS;
    end else begin
      offset_d = sum;
      seg_d    = seg_ovr_en ? seg_ovr_code : dec.dflt_seg;
    end
  end

  // control register
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      valid_q <= 1'b0;
      nomem_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
      if (data_en) nomem_q <= nomem_d;
    end
  end

  // data registers, no reset needed
  always_ff @(posedge clk) begin
    if (data_en) begin
      offset_q <= offset_d;
      seg_q    <= seg_d;
    end
  end

  assign out_valid  = valid_q;
  assign out_offset = offset_q;
  assign out_seg    = seg_q;
  assign out_no_mem = nomem_q;
endmodule

// File: rtl/agu_checker.sv
module agu_checker #(
  parameter int DATA_W    = 32,
  parameter int GPR_BUS_W = 8 * DATA_W
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic [1:0]           mod_code,
  input logic [2:0]           rm_code,
  input logic [DATA_W-1:0]    disp_in,
  input logic                 seg_ovr_en,
  input logic [2:0]           seg_ovr_code,
  input logic [GPR_BUS_W-1:0] gpr_bus,
  input logic                 out_valid,
  input logic [DATA_W-1:0]    out_offset,
  input logic [2:0]           out_seg,
  input logic                 out_no_mem
);
  p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_idle_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_reg_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mod_code == 2'b11) |=> (out_no_mem && out_offset == '0 && out_seg == 3'd3));
  p_override_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mod_code != 2'b11 && seg_ovr_en) |=> (out_seg == $past(seg_ovr_code)));
  p_direct_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mod_code == 2'b00 && rm_code == 3'b101 && !seg_ovr_en)
      |=> (out_offset == $past(disp_in) && out_seg == 3'd3 && !out_no_mem));
  p_byte_disp_eax_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mod_code == 2'b01 && rm_code == 3'b000)
      |=> (out_offset == $past(gpr_bus[DATA_W-1:0] +
                               {{(DATA_W-8){disp_in[7]}}, disp_in[7:0]})));
endmodule

bind mem_offset_agu agu_checker #(.DATA_W(DATA_W), .GPR_BUS_W(GPR_BUS_W)) u_agu_checker (
  .clk          (clk),
  .rst_n        (rst_core_n),
  .in_valid     (in_valid),
  .mod_code     (mod_code),
  .rm_code      (rm_code),
  .disp_in      (disp_in),
  .seg_ovr_en   (seg_ovr_en),
  .seg_ovr_code (seg_ovr_code),
  .gpr_bus      (gpr_bus),
  .out_valid    (out_valid),
  .out_offset   (out_offset),
  .out_seg      (out_seg),
  .out_no_mem   (out_no_mem)
);

// File: tb/mem_offset_agu_bench.sv
`timescale 1ns/1ps
module mem_offset_agu_bench;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [1:0]   mod_code;
  logic [2:0]   rm_code;
  logic [1:0]   sib_scale;
  logic [2:0]   sib_index;
  logic [2:0]   sib_base;
  logic [31:0]  disp_in;
  logic         seg_ovr_en;
  logic [2:0]   seg_ovr_code;
  logic [255:0] gpr_bus;
  logic         out_valid;
  logic [31:0]  out_offset;
  logic [2:0]   out_seg;
  logic         out_no_mem;

  logic [31:0] regs [8];

  typedef struct {
    logic [31:0] offset;
    logic [2:0]  seg;
    logic        no_mem;
    string       tag;
  } exp_t;

  exp_t sb_q[$];
  int   n_checks = 0;
  int   n_fail   = 0;
  bit   mon_on   = 1'b0;
  bit   finished = 1'b0;

  always #2.5 clk = ~clk;

  mem_offset_agu u_mem_offset_agu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mod_code(mod_code),
    .rm_code(rm_code), .sib_scale(sib_scale), .sib_index(sib_index),
    .sib_base(sib_base), .disp_in(disp_in), .seg_ovr_en(seg_ovr_en),
    .seg_ovr_code(seg_ovr_code), .gpr_bus(gpr_bus), .out_valid(out_valid),
    .out_offset(out_offset), .out_seg(out_seg), .out_no_mem(out_no_mem)
  );

  always_comb
    for (int k = 0; k < 8; k++) gpr_bus[32*k +: 32] = regs[k];

  function automatic exp_t model(input logic [1:0] md, input logic [2:0] rm,
                                 input logic [1:0] sc, input logic [2:0] ix,
                                 input logic [2:0] bs, input logic [31:0] dp,
                                 input bit ov, input logic [2:0] oc, input string tag);
    exp_t e;
    logic [31:0] base_v, idx_v, d_v;
    bit has_base;
    logic [2:0] bsel;
    e.tag = tag;
    if (md == 2'd3) begin
      e.offset = 32'd0; e.seg = 3'd3; e.no_mem = 1'b1;
      return e;
    end
    has_base = 1'b1; bsel = rm; idx_v = 32'd0;
    if (md == 2'd1)      d_v = {{24{dp[7]}}, dp[7:0]};
    else if (md == 2'd2) d_v = dp;
    else                 d_v = 32'd0;
    if (rm == 3'd4) begin
      if (ix != 3'd4) idx_v = regs[ix] * (32'd1 << sc);
      if (md == 2'd0 && bs == 3'd5) begin has_base = 1'b0; d_v = dp; end
      else bsel = bs;
    end else if (md == 2'd0 && rm == 3'd5) begin
      has_base = 1'b0; d_v = dp;
    end
    base_v = has_base ? regs[bsel] : 32'd0;
    e.offset = base_v + idx_v + d_v;
    if (ov)                                        e.seg = oc;
    else if (has_base && (bsel == 3'd4 || bsel == 3'd5)) e.seg = 3'd2;
    else                                           e.seg = 3'd3;
    e.no_mem = 1'b0;
    return e;
  endfunction

  task automatic drive(input string tag, input logic [1:0] md, input logic [2:0] rm,
                       input logic [1:0] sc, input logic [2:0] ix, input logic [2:0] bs,
                       input logic [31:0] dp, input bit ov = 1'b0, input logic [2:0] oc = 3'd0);
    @(negedge clk);
    in_valid = 1'b1; mod_code = md; rm_code = rm; sib_scale = sc;
    sib_index = ix; sib_base = bs; disp_in = dp; seg_ovr_en = ov; seg_ovr_code = oc;
    sb_q.push_back(model(md, rm, sc, ix, bs, dp, ov, oc, tag));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (mon_on) begin
        if (out_valid) begin
          n_checks++;
          if (sb_q.size() == 0) begin
            n_fail++;
            $display("FAIL R1: unexpected out_valid actual=1 expected=0");
          end else begin
            exp_t e;
            e = sb_q.pop_front();
            if (out_offset !== e.offset || out_seg !== e.seg || out_no_mem !== e.no_mem) begin
              n_fail++;
              $display("FAIL %s: actual off=%h seg=%0d nomem=%0b expected off=%h seg=%0d nomem=%0b",
                       e.tag, out_offset, out_seg, out_no_mem, e.offset, e.seg, e.no_mem);
            end
          end
        end else if (sb_q.size() != 0 && !in_valid_prev) begin
          n_checks++;
          n_fail++;
          $display("FAIL R1: out_valid actual=0 expected=1 (%s)", sb_q[0].tag);
          void'(sb_q.pop_front());
        end
      end
    end
  end

  logic in_valid_prev;
  always @(posedge clk) in_valid_prev <= 1'b0;

  // watchdog
  initial begin
    #(5.0 * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: run did not end");
    finish_run();
  end

  initial begin
    regs[0] = 32'h1000_0000; regs[1] = 32'h0000_0010;
    regs[2] = 32'h0000_0200; regs[3] = 32'h0003_0000;
    regs[4] = 32'h7FFF_F000; regs[5] = 32'h0010_0000;
    regs[6] = 32'hFFFF_FFF0; regs[7] = 32'h0000_0004;
    rst_n = 1'b0; in_valid = 1'b0; mod_code = 2'd0; rm_code = 3'd0;
    sib_scale = 2'd0; sib_index = 3'd0; sib_base = 3'd0; disp_in = 32'd0;
    seg_ovr_en = 1'b0; seg_ovr_code = 3'd0;
    repeat (4) @(posedge clk);
    #1;
    n_checks++;
    if (out_valid !== 1'b0 || out_no_mem !== 1'b0) begin
      n_fail++;
      $display("FAIL R13: reset state actual valid=%b nomem=%b expected 0 0", out_valid, out_no_mem);
    end
    @(negedge clk); rst_n = 1'b1;
    idle(4);
    mon_on = 1'b1;

    // R2: plain register-indirect bases
    drive("R2 base EAX", 2'd0, 3'd0, 2'd0, 3'd0, 3'd0, 32'hDEAD_BEEF);
    drive("R2 base ECX", 2'd0, 3'd1, 2'd0, 3'd0, 3'd0, 32'h0);
    drive("R2 base EDX", 2'd0, 3'd2, 2'd0, 3'd0, 3'd0, 32'h0);
    drive("R2 base EBX", 2'd0, 3'd3, 2'd0, 3'd0, 3'd0, 32'h0);
    drive("R2 base ESI", 2'd0, 3'd6, 2'd0, 3'd0, 3'd0, 32'h0);
    drive("R2 base EDI", 2'd0, 3'd7, 2'd0, 3'd0, 3'd0, 32'h0);
    // R4: displacement sizes
    drive("R4 disp8 negative", 2'd1, 3'd0, 2'd0, 3'd0, 3'd0, 32'h0000_00F8);
    drive("R4 disp8 positive ignores upper", 2'd1, 3'd2, 2'd0, 3'd0, 3'd0, 32'hFFFF_FF7F);
    drive("R4 disp32", 2'd2, 3'd3, 2'd0, 3'd0, 3'd0, 32'h1234_5678);
    // R5: direct
    drive("R5 direct", 2'd0, 3'd5, 2'd0, 3'd0, 3'd0, 32'hCAFE_0010);
    idle(2);
    // R3: scales, base EBX index EDI
    for (int s = 0; s < 4; s++)
      drive("R3 scale", 2'd0, 3'd4, s[1:0], 3'd7, 3'd3, 32'h0);
    drive("R3 scale disp32", 2'd2, 3'd4, 2'd1, 3'd1, 3'd2, 32'h0000_0100);
    // R6: no base SIB
    drive("R6 no base", 2'd0, 3'd4, 2'd3, 3'd1, 3'd5, 32'h0000_1000);
    // R7: EBP base
    drive("R7 EBP disp8 zero", 2'd1, 3'd5, 2'd0, 3'd0, 3'd0, 32'h0);
    drive("R7 EBP SIB disp32", 2'd2, 3'd4, 2'd2, 3'd7, 3'd5, 32'h0000_0040);
    // R8: index code 100 adds zero
    drive("R8 no index scale8", 2'd0, 3'd4, 2'd3, 3'd4, 3'd1, 32'h0);
    drive("R8 no index ESP base", 2'd1, 3'd4, 2'd2, 3'd4, 3'd4, 32'h0000_0008);
    // R9: default segments
    drive("R9 ESP base SS", 2'd0, 3'd4, 2'd0, 3'd1, 3'd4, 32'h0);
    drive("R9 index EBP stays DS", 2'd0, 3'd4, 2'd0, 3'd5, 3'd0, 32'h0);
    // R10: override
    drive("R10 override ES on EBP", 2'd1, 3'd5, 2'd0, 3'd0, 3'd0, 32'h4, 1'b1, 3'd0);
    drive("R10 override GS direct", 2'd0, 3'd5, 2'd0, 3'd0, 3'd0, 32'h80, 1'b1, 3'd5);
    // R11: register-only
    drive("R11 reg only", 2'd3, 3'd1, 2'd0, 3'd0, 3'd0, 32'h55, 1'b1, 3'd4);
    drive("R11 then memory clears flag", 2'd0, 3'd1, 2'd0, 3'd0, 3'd0, 32'h0);
    // R12: wrap
    drive("R12 wrap", 2'd2, 3'd6, 2'd0, 3'd0, 3'd0, 32'h0000_0020);
    drive("R12 wrap scaled", 2'd0, 3'd4, 2'd3, 3'd6, 3'd6, 32'h0);
    // R1: idle gap after traffic
    idle(3);
    drive("R1 single after gap", 2'd0, 3'd7, 2'd0, 3'd0, 3'd0, 32'h0);
    idle(4);
    n_checks++;
    if (sb_q.size() != 0) begin
      n_fail++;
      $display("FAIL R1: results missing actual=%0d pending expected=0", sb_q.size());
    end
    finish_run();
  end
endmodule